// File: doc/BRIEF.md
# I2C Target Address-Phase Status Tracker

This block listens to the clock and data lines of a two-wire bus as a target. It brings both lines into the system clock domain through a synchronizer chain and detects START, repeated START and STOP conditions. It tracks whether the bus is in use and shifts in the first byte after every START. At the eighth SCL rising edge it compares the 7-bit address in that byte against two programmable own addresses and three fixed special addresses. When a compare hits, it latches the match flags and the transfer direction.

The flags are presented as a read-only 16-bit status word. Its upper byte carries an externally computed packet-error-check value. A separate address-matched output is cleared by a two-step read sequence: a strobe on the first status register followed later by a strobe on this one. A host that drives those two strobes can poll the tracker the way software would poll a status register pair.

Top module: `i2c_addr_tracker`

## Requirements
- R1: After reset the status word is 0x0000 and addrMatched is 0.
- R2: Status bits 15:8 equal pecIn when pecEn is 1 and 0 when pecEn is 0. Bits 3 and 0 always read 0. Bit 7 is dual, bit 6 host, bit 5 default, bit 4 general call, bit 2 direction and bit 1 busy.
- R3: Busy (bit 1) sets when either synchronized line is low and clears on STOP (SDA rising while SCL is high). This holds whether enable is 1 or 0.
- R4: A received address equal to ownAddr1 sets addrMatched and leaves bit 7 at 0. The address is the first 7 bits after START, MSB first.
- R5: A received address equal to ownAddr2 while dualEn is 1, and not equal to ownAddr1, sets addrMatched and bit 7. With dualEn at 0 that address does not match.
- R6: Address 0x00 sets bit 4 and addrMatched only when genCallEn is 1.
- R7: Address 0x08 sets bit 6 only when both smbHostType and arpEn are 1. Address 0x61 sets bit 5 only when arpEn is 1.
- R8: On a match, bit 2 takes the eighth bit of the byte (1 = transmitting, 0 = receiving). A pulse on arbLost clears bit 2 and leaves the other flags unchanged.
- R9: A STOP or a repeated START (SDA falling while SCL is high) clears bits 7, 6, 5, 4 and 2.
- R10: While enable is 0, bits 7, 6, 5, 4 and 2 and addrMatched are held at 0 and no address matches.
- R11: A rdSecond strobe that follows an earlier rdFirst strobe clears addrMatched. This includes a flag that was set between the two strobes. A rdSecond strobe with no rdFirst before it has no effect.
- R12: A byte whose address hits no enabled compare changes neither addrMatched nor any status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line, asynchronous |
| sdaIn | input | 1 | Bus data line, asynchronous |
| enable | input | 1 | Peripheral enable |
| ownAddr1 | input | 7 | First own address |
| ownAddr2 | input | 7 | Second own address |
| dualEn | input | 1 | Enables compare against ownAddr2 |
| genCallEn | input | 1 | Enables general-call compare |
| arpEn | input | 1 | Enables address-resolution compares |
| smbHostType | input | 1 | Selects host type for the host-address compare |
| pecEn | input | 1 | Shows pecIn in the status word |
| pecIn | input | 8 | Externally computed check byte |
| arbLost | input | 1 | Arbitration-loss pulse |
| rdFirst | input | 1 | Read strobe of the first status register |
| rdSecond | input | 1 | Read strobe of this status register |
| statusWord | output | 16 | Read-only status word |
| addrMatched | output | 1 | Address-matched flag |

## Verification
A wrong bit counter or shift order shows up as a missing or spurious addrMatched. It is visible a few clocks after the eighth SCL rise of the address byte, because only that edge can set the flags. A flag that is not cleared, or is cleared at the wrong time, persists in the status word past the following STOP or repeated START, so the check made right after that condition catches it. A stale read-sequence arm shows up as addrMatched dropping on a lone rdSecond strobe.

// File: rtl/i2c_trk_pkg.sv
package i2c_trk_pkg;
  localparam int ADDR_W = 7;
  localparam int PEC_W  = 8;
  localparam int STAT_W = 16;

  localparam logic [ADDR_W-1:0] GC_ADDR   = 7'h00;
  localparam logic [ADDR_W-1:0] HOST_ADDR = 7'h08;
  localparam logic [ADDR_W-1:0] DFLT_ADDR = 7'h61;

  // strobes and levels handed from control to datapath
  typedef struct packed {
    logic startDet;
    logic stopDet;
    logic sclRise;
    logic addrLast;
    logic sdaBit;
    logic lineLow;
  } ctlStrobe_t;
endpackage

// File: rtl/i2c_trk_sync.sv
module i2c_trk_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] lineAsync,
  output logic [WIDTH-1:0] lineSync
);
  localparam int CHAIN_W = WIDTH * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= RESET_VAL;
        else       chain <= lineAsync;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= {STAGES{RESET_VAL}};
        else       chain <= {chain[CHAIN_W-WIDTH-1:0], lineAsync};
      end
    end
  endgenerate

  assign lineSync = chain[CHAIN_W-1 -: WIDTH];
endmodule

// File: rtl/i2c_trk_ctrl.sv
module i2c_trk_ctrl
  import i2c_trk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output ctlStrobe_t ctl
);
  localparam int CNT_W = $clog2(AW + 2);

  logic [1:0] lineSync;
  logic scl, sda, sclPrev, sdaPrev;
  logic active;
  logic [CNT_W-1:0] bitCnt;

  i2c_trk_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RESET_VAL(2'b11)) u_sync (
    .clk(clk),
    .rstN(rstN),
    .lineAsync({sclIn, sdaIn}),
    .lineSync(lineSync)
  );

  assign scl = lineSync[1];
  assign sda = lineSync[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= scl;
      sdaPrev <= sda;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.startDet = scl & sclPrev & sdaPrev & ~sda;
    ctl.stopDet  = scl & sclPrev & ~sdaPrev & sda;
    ctl.sclRise  = scl & ~sclPrev;
    ctl.addrLast = scl & ~sclPrev & active & (bitCnt == CNT_W'(AW));
    ctl.sdaBit   = sda;
    ctl.lineLow  = ~scl | ~sda;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (ctl.startDet) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (ctl.stopDet) begin
      active <= 1'b0;
    end else if (ctl.sclRise && active) begin
      bitCnt <= bitCnt + 1'b1;
      if (ctl.addrLast) active <= 1'b0;
    end
  end

  // R3
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.startDet, ctl.stopDet, ctl.sclRise}));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(AW + 1));

  // R4
  phase_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.addrLast |=> !active);
endmodule

// File: rtl/i2c_trk_dp.sv
module i2c_trk_dp
  import i2c_trk_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int PW = PEC_W,
  parameter int SW = STAT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobe_t    ctl,
  input  logic          enable,
  input  logic [AW-1:0] ownAddr1,
  input  logic [AW-1:0] ownAddr2,
  input  logic          dualEn,
  input  logic          genCallEn,
  input  logic          arpEn,
  input  logic          smbHostType,
  input  logic          pecEn,
  input  logic [PW-1:0] pecIn,
  input  logic          arbLost,
  input  logic          rdFirst,
  input  logic          rdSecond,
  output logic [SW-1:0] statusWord,
  output logic          addrMatched
);
  localparam int LOW_W = SW - PW;

  logic [AW-1:0] shiftReg;
  logic hitOwn1, hitOwn2, hitGc, hitHost, hitDflt, anyHit, takeAddr, clrPhase;
  logic dualFlag, gcFlag, hostFlag, dfltFlag, traFlag, busyFlag, readArmed;
  logic [LOW_W-1:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shiftReg <= '0;
    else if (ctl.sclRise) shiftReg <= {shiftReg[AW-2:0], ctl.sdaBit};
  end

  always_comb begin
    hitOwn1  = (shiftReg == ownAddr1);
    hitOwn2  = dualEn && (shiftReg == ownAddr2);
    hitGc    = genCallEn && (shiftReg == GC_ADDR);
    hitHost  = arpEn && smbHostType && (shiftReg == HOST_ADDR);
    hitDflt  = arpEn && (shiftReg == DFLT_ADDR);
    anyHit   = hitOwn1 | hitOwn2 | hitGc | hitHost | hitDflt;
    takeAddr = ctl.addrLast && enable && anyHit;
    clrPhase = !enable || ctl.startDet || ctl.stopDet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dualFlag <= 1'b0;
      gcFlag   <= 1'b0;
      hostFlag <= 1'b0;
      dfltFlag <= 1'b0;
    end else if (clrPhase) begin
      dualFlag <= 1'b0;
      gcFlag   <= 1'b0;
      hostFlag <= 1'b0;
      dfltFlag <= 1'b0;
    end else if (takeAddr) begin
      dualFlag <= hitOwn2 & ~hitOwn1;
      gcFlag   <= hitGc;
      hostFlag <= hitHost;
      dfltFlag <= hitDflt;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    traFlag <= 1'b0;
    else if (clrPhase || arbLost) traFlag <= 1'b0;
    else if (takeAddr)            traFlag <= ctl.sdaBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            busyFlag <= 1'b0;
    else if (ctl.stopDet) busyFlag <= 1'b0;
    else if (ctl.lineLow) busyFlag <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readArmed   <= 1'b0;
      addrMatched <= 1'b0;
    end else if (!enable) begin
      readArmed   <= 1'b0;
      addrMatched <= 1'b0;
    end else begin
      if (rdSecond)     readArmed <= 1'b0;
      else if (rdFirst) readArmed <= 1'b1;
      if (takeAddr)                   addrMatched <= 1'b1;
      else if (rdSecond && readArmed) addrMatched <= 1'b0;
    end
  end

  always_comb begin
    lowBits    = '0;
    lowBits[7] = dualFlag;
    lowBits[6] = hostFlag;
    lowBits[5] = dfltFlag;
    lowBits[4] = gcFlag;
    lowBits[2] = traFlag;
    lowBits[1] = busyFlag;
  end

  assign statusWord = {(pecEn ? pecIn : {PW{1'b0}}), lowBits};

  // R3
  busy_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stopDet |=> !statusWord[1]);

  // R3
  busy_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.lineLow && !ctl.stopDet) |=> statusWord[1]);

  // R9
  phase_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.startDet || ctl.stopDet) |=> (statusWord[7:4] == 4'b0 && !statusWord[2]));

  // R10
  disabled_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!addrMatched && statusWord[7:4] == 4'b0 && !statusWord[2]));

  // R8
  arb_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    arbLost |=> !statusWord[2]);

  // R4
  match_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    takeAddr |=> addrMatched);

  // R12
  no_hit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.addrLast && !anyHit && enable && !rdSecond && !arbLost) |=>
      ($stable(addrMatched) && $stable(statusWord[7:1])));
endmodule

// File: rtl/i2c_addr_tracker.sv
module i2c_addr_tracker
  import i2c_trk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              enable,
  input  logic [ADDR_W-1:0] ownAddr1,
  input  logic [ADDR_W-1:0] ownAddr2,
  input  logic              dualEn,
  input  logic              genCallEn,
  input  logic              arpEn,
  input  logic              smbHostType,
  input  logic              pecEn,
  input  logic [PEC_W-1:0]  pecIn,
  input  logic              arbLost,
  input  logic              rdFirst,
  input  logic              rdSecond,
  output logic [STAT_W-1:0] statusWord,
  output logic              addrMatched
);
  ctlStrobe_t ctl;

  i2c_trk_ctrl #(.AW(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .ctl(ctl)
  );

  i2c_trk_dp #(.AW(ADDR_W), .PW(PEC_W), .SW(STAT_W)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .ctl(ctl),
    .enable(enable),
    .ownAddr1(ownAddr1),
    .ownAddr2(ownAddr2),
    .dualEn(dualEn),
    .genCallEn(genCallEn),
    .arpEn(arpEn),
    .smbHostType(smbHostType),
    .pecEn(pecEn),
    .pecIn(pecIn),
    .arbLost(arbLost),
    .rdFirst(rdFirst),
    .rdSecond(rdSecond),
    .statusWord(statusWord),
    .addrMatched(addrMatched)
  );
endmodule

// File: tb/i2c_addr_tracker_tb_top.sv
module i2c_addr_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclLine = 1'b1, sdaLine = 1'b1;
  logic enable = 1'b0;
  logic [6:0] ownAddr1 = 7'h22, ownAddr2 = 7'h44;
  logic dualEn = 1'b0, genCallEn = 1'b0, arpEn = 1'b0, smbHostType = 1'b0;
  logic pecEn = 1'b0;
  logic [7:0] pecIn = 8'h00;
  logic arbLost = 1'b0, rdFirst = 1'b0, rdSecond = 1'b0;
  logic [15:0] statusWord;
  logic addrMatched;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_addr_tracker dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine), .enable(enable),
    .ownAddr1(ownAddr1), .ownAddr2(ownAddr2), .dualEn(dualEn), .genCallEn(genCallEn),
    .arpEn(arpEn), .smbHostType(smbHostType), .pecEn(pecEn), .pecIn(pecIn),
    .arbLost(arbLost), .rdFirst(rdFirst), .rdSecond(rdSecond),
    .statusWord(statusWord), .addrMatched(addrMatched)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busStart();
    sdaLine = 1'b1; sclLine = 1'b1; waitClk(HOLD);
    sdaLine = 1'b0; waitClk(HOLD);
  endtask

  task automatic busRepStart();
    sclLine = 1'b0; waitClk(HOLD);
    sdaLine = 1'b1; waitClk(HOLD);
    sclLine = 1'b1; waitClk(HOLD);
    sdaLine = 1'b0; waitClk(HOLD);
  endtask

  task automatic busStop();
    sclLine = 1'b0; waitClk(HOLD);
    sdaLine = 1'b0; waitClk(HOLD);
    sclLine = 1'b1; waitClk(HOLD);
    sdaLine = 1'b1; waitClk(HOLD);
  endtask

  task automatic sendBit(input logic b);
    sclLine = 1'b0; waitClk(HOLD);
    sdaLine = b;    waitClk(HOLD);
    sclLine = 1'b1; waitClk(HOLD);
  endtask

  task automatic sendAddr(input logic [6:0] a, input logic rw);
    for (int i = 6; i >= 0; i--) sendBit(a[i]);
    sendBit(rw);
    waitClk(HOLD);
  endtask

  task automatic pulseRead(input bit second);
    @(negedge clk);
    if (second) rdSecond = 1'b1; else rdFirst = 1'b1;
    @(negedge clk);
    rdFirst = 1'b0; rdSecond = 1'b0;
  endtask

  // model: returns {matched, statusWord} after an address byte, busy=1
  function automatic logic [16:0] expAfterAddr(input logic [6:0] a, input logic rw);
    logic h1, h2, gc, hst, dft, any;
    logic [15:0] w;
    h1  = (a == ownAddr1);
    h2  = dualEn && (a == ownAddr2);
    gc  = genCallEn && (a == 7'h00);
    hst = arpEn && smbHostType && (a == 7'h08);
    dft = arpEn && (a == 7'h61);
    any = h1 | h2 | gc | hst | dft;
    w = '0;
    w[15:8] = pecEn ? pecIn : 8'h00;
    w[7] = any & h2 & ~h1;
    w[6] = any & hst;
    w[5] = any & dft;
    w[4] = any & gc;
    w[2] = any & rw;
    w[1] = 1'b1;
    return {any, w};
  endfunction

  function automatic logic [15:0] expIdle();
    return {(pecEn ? pecIn : 8'h00), 8'h00};
  endfunction

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [16:0] e;
    logic [6:0] a;
    logic rw;
    void'($urandom(32'h5eed_1234));
    waitClk(3);
    // R1 reset state
    check("R1 status at reset", statusWord, 16'h0000);
    check("R1 matched at reset", addrMatched, 1'b0);
    rstN = 1'b1;
    waitClk(4);
    check("R1 status after reset release", statusWord, 16'h0000);

    // R2 check byte visibility
    pecIn = 8'hA5; pecEn = 1'b1; waitClk(1);
    check("R2 pec shown", statusWord[15:8], 8'hA5);
    pecEn = 1'b0; waitClk(1);
    check("R2 pec hidden", statusWord[15:8], 8'h00);

    // R3 R10 busy while disabled, no match while disabled
    enable = 1'b0;
    busStart();
    check("R3 busy set while disabled", statusWord[1], 1'b1);
    sendAddr(ownAddr1, 1'b1);
    check("R10 no match while disabled", addrMatched, 1'b0);
    check("R10 flags zero while disabled", statusWord[7:2], 6'h00);
    busStop();
    check("R3 busy cleared by stop while disabled", statusWord[1], 1'b0);
    enable = 1'b1; waitClk(2);

    // R12 no-hit byte leaves flags alone
    busStart(); sendAddr(ownAddr1, 1'b0);
    check("R4 own1 match", addrMatched, 1'b1);
    check("R4 dual low on own1", statusWord[7], 1'b0);
    busStop();
    check("R9 flags cleared by stop", statusWord[7:2], 6'h00);
    check("R3 busy low after stop", statusWord[1], 1'b0);
    busStart(); sendAddr(7'h33, 1'b1);
    check("R12 matched held on no hit", addrMatched, 1'b1);
    check("R12 flags unchanged on no hit", statusWord[7:2], 6'h00);
    busStop();

    // R11 lone rdSecond has no effect, then proper sequence clears
    pulseRead(1'b1); waitClk(2);
    check("R11 lone second read ignored", addrMatched, 1'b1);
    pulseRead(1'b0); waitClk(3); pulseRead(1'b1); waitClk(2);
    check("R11 read sequence clears", addrMatched, 1'b0);

    // R11 race: flag set between the two reads
    pulseRead(1'b0);
    busStart(); sendAddr(ownAddr1, 1'b0);
    check("R11 set between reads", addrMatched, 1'b1);
    pulseRead(1'b1); waitClk(2);
    check("R11 cleared after race", addrMatched, 1'b0);
    busStop();

    // R5 R9 repeated start clears own2 / direction
    dualEn = 1'b1;
    busStart(); sendAddr(ownAddr2, 1'b1);
    check("R5 dual flag on own2", statusWord[7], 1'b1);
    check("R8 transmit direction", statusWord[2], 1'b1);
    busRepStart();
    check("R9 repeated start clears flags", statusWord[7:2], 6'h00);
    check("R9 busy kept over repeated start", statusWord[1], 1'b1);
    busStop();
    pulseRead(1'b0); pulseRead(1'b1);
    dualEn = 1'b0;
    busStart(); sendAddr(ownAddr2, 1'b0);
    check("R5 own2 ignored when dual off", addrMatched, 1'b0);
    busStop();

    // R8 arbitration loss clears only direction
    dualEn = 1'b1;
    busStart(); sendAddr(ownAddr2, 1'b1);
    @(negedge clk) arbLost = 1'b1;
    @(negedge clk) arbLost = 1'b0;
    waitClk(1);
    check("R8 direction cleared by arb loss", statusWord[2], 1'b0);
    check("R8 dual kept on arb loss", statusWord[7], 1'b1);
    check("R8 matched kept on arb loss", addrMatched, 1'b1);

    // R10 disable clears flags and matched
    enable = 1'b0; waitClk(2);
    check("R10 disable clears flags", statusWord[7:2], 6'h00);
    check("R10 disable clears matched", addrMatched, 1'b0);
    check("R3 busy kept while disabled", statusWord[1], 1'b1);
    busStop();
    enable = 1'b1; waitClk(2);

    // R6 R7 special addresses, random configuration
    for (int it = 0; it < 60; it++) begin
      int pick;
      ownAddr1 = 7'($urandom); ownAddr2 = 7'($urandom);
      dualEn = 1'($urandom); genCallEn = 1'($urandom); arpEn = 1'($urandom);
      smbHostType = 1'($urandom); pecEn = 1'($urandom); pecIn = 8'($urandom);
      pick = int'($urandom % 6);
      case (pick)
        0: a = ownAddr1;
        1: a = ownAddr2;
        2: a = 7'h00;
        3: a = 7'h08;
        4: a = 7'h61;
        default: a = 7'($urandom);
      endcase
      rw = 1'($urandom);
      e = expAfterAddr(a, rw);
      busStart(); sendAddr(a, rw);
      check("R4 R5 R6 R7 R8 matched after address", addrMatched, e[16]);
      check("R2 R6 R7 status after address", statusWord, e[15:0]);
      busStop();
      check("R9 R3 status after stop", statusWord, expIdle());
      pulseRead(1'b0); pulseRead(1'b1); waitClk(1);
      check("R11 cleared by reads", addrMatched, 1'b0);
    end

    finishRun();
  end
endmodule